// File: doc/BRIEF.md
# Grouped Event Flag Combiner

This block catches single-cycle and level events on a wide input bus and keeps each one as a sticky flag bit. The flags are split into groups of equal width. Software reaches the flags through a small word-addressed register bus. It can set or clear flags with write-one semantics, program two independent mask sets, and read the flags both raw and through either mask.

Each group drives one registered interrupt line. That line is high while any flag in the group is set and not blocked by the group's event mask. A second mask set, the exception mask, filters the same flags into a separate readable status. This lets one event be serviced through the interrupt line, through the exception path, or through both. A dedicated assert register lets software raise any single event by its number.

The bus address is `{func[2:0], group}`. The group field is the low `GRP_AW` bits. Function codes: 0 raw flags (read), 1 set (write), 2 clear (write), 3 event mask (read/write), 4 event-masked flags (read), 5 exception mask (read/write), 6 exception-masked flags (read), 7 event assert (write, the group field is ignored). Reads of write-only functions return 0, and writes to read-only functions change nothing.

Top module: `evt_combiner`

## Requirements
- R1: After reset every flag is 0, every event-mask and exception-mask bit is 1, and every `grp_irq` bit is 0.
- R2: A 0-to-1 transition on `evt_in[n]` sets flag n (group n/32, bit n mod 32) at the next clock edge. An input held high does not set the flag again after software clears it.
- R3: A write to function 1 sets every flag of the addressed group whose `bus_wdata` bit is 1. Bits written as 0 leave their flags unchanged.
- R4: A write to function 2 clears every flag of the addressed group whose `bus_wdata` bit is 1. Bits written as 0 leave their flags unchanged.
- R5: When a hardware set and a software clear hit the same flag at the same edge, the flag ends up set.
- R6: The event mask of a group is read and written at function 3. A mask bit of 1 keeps its flag out of `grp_irq`, and a mask bit of 0 lets it through.
- R7: A read of function 4 returns the group's flags ANDed with the inverse of its event mask.
- R8: The exception mask is read and written at function 5. A read of function 6 returns the flags ANDed with the inverse of the exception mask. The exception mask has no effect on `grp_irq` or on function 4.
- R9: `grp_irq[g]` is registered. It follows the group's flag and event-mask state one clock later, and it stays high for as long as an unmasked flag stays set.
- R10: A write to function 7 sets flag number `bus_wdata[6:0]`, which is group `bus_wdata[6:5]`, bit `bus_wdata[4:0]`.
- R11: A set flag stays set, with no further input activity, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_GROUPS*GROUP_W (128) | Event inputs; a rising edge sets the flag |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3+GRP_AW (5) | `{func, group}` word address |
| bus_wdata | input | GROUP_W (32) | Write data |
| bus_rdata | output | GROUP_W (32) | Read data, combinational from `bus_addr` |
| grp_irq | output | NUM_GROUPS (4) | Registered per-group combined interrupt |

## Verification
The bench drives a hardware rise on an event in the same cycle that software clears that event. A design that gives priority to the clear loses the event and reads back 0. It clears a flag while its input is still held high, which catches an edge detector that is really level-sensitive and sets the flag again. It samples `grp_irq` in the cycle right after a mask or flag change, where the registered output must still show its old value, and again one cycle later. This catches both a combinational output and an output that lags by two stages. The exception mask is programmed differently from the event mask to show that the two paths do not leak into each other. An assert to event 100 must land in group 3, bit 4.

// File: rtl/evt_combiner_pkg.sv
package evt_combiner_pkg;

    localparam int FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_RAW    = 3'd0,
        FN_SET    = 3'd1,
        FN_CLR    = 3'd2,
        FN_EMASK  = 3'd3,
        FN_ESTAT  = 3'd4,
        FN_XMASK  = 3'd5,
        FN_XSTAT  = 3'd6,
        FN_ASSERT = 3'd7
    } reg_func_e;

endpackage

// File: rtl/evt_edge_detect.sv
module evt_edge_detect #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_in,
    output logic [WIDTH-1:0] rise_o
);

    typedef struct packed {
        logic [WIDTH-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_in;
        rise_o    = level_in & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/evt_flag_group.sv
module evt_flag_group #(
    parameter int GROUP_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GROUP_W-1:0] set_in,
    input  logic               sw_set_we,
    input  logic               sw_clr_we,
    input  logic               emask_we,
    input  logic               xmask_we,
    input  logic [GROUP_W-1:0] wdata,
    output logic [GROUP_W-1:0] flag_o,
    output logic [GROUP_W-1:0] emask_o,
    output logic [GROUP_W-1:0] xmask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [GROUP_W-1:0] flag;
        logic [GROUP_W-1:0] emask;
        logic [GROUP_W-1:0] xmask;
        logic               irq;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [GROUP_W-1:0] clr_bits;
    logic [GROUP_W-1:0] swset_bits;

    always_comb begin
        st_d       = st_q;
        clr_bits   = sw_clr_we ? wdata : '0;
        swset_bits = sw_set_we ? wdata : '0;
        // the set terms are applied after the clear, so a set always wins
        st_d.flag  = (st_q.flag & ~clr_bits) | set_in | swset_bits;
        if (emask_we) st_d.emask = wdata;
        if (xmask_we) st_d.xmask = wdata;
        st_d.irq   = |(st_q.flag & ~st_q.emask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag  <= '0;
            st_q.emask <= '1;
            st_q.xmask <= '1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign emask_o = st_q.emask;
    assign xmask_o = st_q.xmask;
    assign irq_o   = st_q.irq;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_in) |=> ((flag_o & $past(set_in)) == $past(set_in))); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr_we |=> ((flag_o & $past(wdata & ~set_in)) == '0)); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_clr_we |=> ((flag_o & $past(flag_o)) == $past(flag_o))); // R11

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flag_o & ~emask_o)) |=> irq_o); // R9

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flag_o & ~emask_o)) |=> !irq_o); // R6

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner
    import evt_combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_W    = 32,
    parameter int GRP_AW     = $clog2(NUM_GROUPS),
    parameter int ADDR_W     = FUNC_W + GRP_AW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_GROUPS*GROUP_W-1:0] evt_in,
    input  logic                          bus_we,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [GROUP_W-1:0]            bus_wdata,
    output logic [GROUP_W-1:0]            bus_rdata,
    output logic [NUM_GROUPS-1:0]         grp_irq
);

    localparam int NUM_EVT = NUM_GROUPS * GROUP_W;
    localparam int EVT_AW  = $clog2(NUM_EVT);

    reg_func_e           func;
    logic [GRP_AW-1:0]   grp;
    logic                grp_ok;
    logic [NUM_EVT-1:0]  hw_rise;
    logic [NUM_EVT-1:0]  assert_vec;
    logic [NUM_EVT-1:0]  flag_flat;
    logic [EVT_AW-1:0]   assert_num;
    logic [GROUP_W-1:0]  flag_a  [NUM_GROUPS];
    logic [GROUP_W-1:0]  emask_a [NUM_GROUPS];
    logic [GROUP_W-1:0]  xmask_a [NUM_GROUPS];

    assign func       = reg_func_e'(bus_addr[ADDR_W-1 -: FUNC_W]);
    assign grp        = bus_addr[GRP_AW-1:0];
    assign grp_ok     = (32'(grp) < NUM_GROUPS);
    assign assert_num = bus_wdata[EVT_AW-1:0];

    always_comb begin
        assert_vec = '0;
        if (bus_we && func == FN_ASSERT && 32'(assert_num) < NUM_EVT)
            assert_vec[assert_num] = 1'b1;
    end

    evt_edge_detect #(.WIDTH(NUM_EVT)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (evt_in),
        .rise_o   (hw_rise)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic sel;
        assign sel = bus_we && grp_ok && (32'(grp) == g);

        evt_flag_group #(.GROUP_W(GROUP_W)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_in    (hw_rise[g*GROUP_W +: GROUP_W] | assert_vec[g*GROUP_W +: GROUP_W]),
            .sw_set_we (sel && func == FN_SET),
            .sw_clr_we (sel && func == FN_CLR),
            .emask_we  (sel && func == FN_EMASK),
            .xmask_we  (sel && func == FN_XMASK),
            .wdata     (bus_wdata),
            .flag_o    (flag_a[g]),
            .emask_o   (emask_a[g]),
            .xmask_o   (xmask_a[g]),
            .irq_o     (grp_irq[g])
        );

        assign flag_flat[g*GROUP_W +: GROUP_W] = flag_a[g];
    end

    always_comb begin
        bus_rdata = '0;
        if (grp_ok) begin
            case (func)
                FN_RAW:   bus_rdata = flag_a[grp];
                FN_EMASK: bus_rdata = emask_a[grp];
                FN_ESTAT: bus_rdata = flag_a[grp] & ~emask_a[grp];
                FN_XMASK: bus_rdata = xmask_a[grp];
                FN_XSTAT: bus_rdata = flag_a[grp] & ~xmask_a[grp];
                default:  bus_rdata = '0;
            endcase
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_flat == '0 && grp_irq == '0)); // R1

    AST_ASSERT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && func == FN_ASSERT) |=> flag_flat[$past(assert_num)]); // R10

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_rise) |=> ((flag_flat & $past(hw_rise)) == $past(hw_rise))); // R2

endmodule

// File: tb/sim_evt_combiner.sv
`timescale 1ns/1ps
module sim_evt_combiner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_in = '0;
    logic         bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   grp_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    evt_combiner u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq(grp_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] fn, input logic [1:0] g, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = {fn, g}; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] fn, input logic [1:0] g, output logic [31:0] d);
        @(negedge clk);
        bus_addr = {fn, g};
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", {28'd0, grp_irq}, 32'd0);
        for (int g = 0; g < 4; g++) begin
            rd(3'd0, 2'(g), v); chk("R1 flags", v, 32'h0);
            rd(3'd3, 2'(g), v); chk("R1 emask", v, 32'hFFFF_FFFF);
            rd(3'd5, 2'(g), v); chk("R1 xmask", v, 32'hFFFF_FFFF);
        end
    endtask

    task automatic t_sw_set_clear();
        logic [31:0] v;
        wr(3'd1, 2'd1, 32'h0000_00A5); rd(3'd0, 2'd1, v); chk("R3 set", v, 32'h0000_00A5);
        wr(3'd1, 2'd1, 32'h0);         rd(3'd0, 2'd1, v); chk("R3 zero set", v, 32'h0000_00A5);
        wr(3'd2, 2'd1, 32'h0000_0005); rd(3'd0, 2'd1, v); chk("R4 clear", v, 32'h0000_00A0);
        wr(3'd2, 2'd1, 32'h0);         rd(3'd0, 2'd1, v); chk("R4 zero clear", v, 32'h0000_00A0);
        rd(3'd0, 2'd0, v); chk("R3 other group", v, 32'h0);
        wr(3'd2, 2'd1, 32'hFFFF_FFFF); rd(3'd0, 2'd1, v); chk("R4 clear all", v, 32'h0);
    endtask

    task automatic t_hw_edge();
        logic [31:0] v;
        @(negedge clk); evt_in[70] = 1'b1;
        @(negedge clk); evt_in[70] = 1'b0;
        rd(3'd0, 2'd2, v); chk("R2 pulse", v, 32'h0000_0040);
        repeat (5) @(negedge clk);
        rd(3'd0, 2'd2, v); chk("R11 sticky", v, 32'h0000_0040);
        @(negedge clk); evt_in[71] = 1'b1;
        rd(3'd0, 2'd2, v); chk("R2 level rise", v, 32'h0000_00C0);
        wr(3'd2, 2'd2, 32'h0000_00C0);
        repeat (3) @(negedge clk);
        rd(3'd0, 2'd2, v); chk("R2 held no reset", v, 32'h0);
        evt_in[71] = 1'b0;
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        evt_in[33] = 1'b1;
        bus_we = 1'b1; bus_addr = {3'd2, 2'd1}; bus_wdata = 32'h0000_0002;
        @(negedge clk);
        bus_we = 1'b0; evt_in[33] = 1'b0;
        rd(3'd0, 2'd1, v); chk("R5 set wins", v, 32'h0000_0002);
        wr(3'd2, 2'd1, 32'h0000_0002);
        rd(3'd0, 2'd1, v); chk("R4 later clear", v, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        wr(3'd1, 2'd3, 32'h8000_0000);
        repeat (2) @(negedge clk);
        chk("R6 masked irq", {31'd0, grp_irq[3]}, 32'd0);
        rd(3'd4, 2'd3, v); chk("R7 masked status", v, 32'h0);
        wr(3'd3, 2'd3, 32'h7FFF_FFFF);
        chk("R9 one cycle lag", {31'd0, grp_irq[3]}, 32'd0);
        @(negedge clk);
        chk("R6 unmasked irq", {31'd0, grp_irq[3]}, 32'd1);
        rd(3'd3, 2'd3, v); chk("R6 mask readback", v, 32'h7FFF_FFFF);
        rd(3'd4, 2'd3, v); chk("R7 status", v, 32'h8000_0000);
        rd(3'd6, 2'd3, v); chk("R8 xstat independent", v, 32'h0);
        repeat (6) @(negedge clk);
        chk("R9 level held", {31'd0, grp_irq[3]}, 32'd1);
        wr(3'd2, 2'd3, 32'h8000_0000);
        chk("R9 clear lag", {31'd0, grp_irq[3]}, 32'd1);
        @(negedge clk);
        chk("R9 drops", {31'd0, grp_irq[3]}, 32'd0);
    endtask

    task automatic t_xmask();
        logic [31:0] v;
        wr(3'd5, 2'd0, 32'hFFFF_00FF);
        wr(3'd1, 2'd0, 32'h0000_0F0F);
        rd(3'd5, 2'd0, v); chk("R8 xmask readback", v, 32'hFFFF_00FF);
        rd(3'd6, 2'd0, v); chk("R8 xstat", v, 32'h0000_0F00);
        rd(3'd4, 2'd0, v); chk("R8 estat unaffected", v, 32'h0);
        chk("R8 irq unaffected", {31'd0, grp_irq[0]}, 32'd0);
        wr(3'd2, 2'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_assert();
        logic [31:0] v;
        wr(3'd7, 2'd0, 32'd100);
        rd(3'd0, 2'd3, v); chk("R10 event 100", v, 32'h0000_0010);
        wr(3'd7, 2'd2, 32'd0);
        rd(3'd0, 2'd0, v); chk("R10 event 0", v, 32'h0000_0001);
        rd(3'd0, 2'd2, v); chk("R10 group field ignored", v, 32'h0);
        rd(3'd7, 2'd0, v); chk("R10 read zero", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_set_clear();
        t_hw_edge();
        t_set_wins();
        t_mask_irq();
        t_xmask();
        t_assert();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule